// File: doc/BRIEF.md
# RAID-6 partial-stripe parity updater

This block refreshes the two redundancy words of a RAID-6 stripe, the XOR parity P and the Reed-Solomon syndrome Q. It is used when only a contiguous run of data disks has been rewritten, from a low index `start_idx` up to a high index `stop_idx`. The block does not need the whole stripe. For each rewritten disk it takes the delta (old data XOR new data). It also takes the old P and old Q words of the same column, and it returns the new P and new Q. Every word holds `LANES` independent byte lanes. Q arithmetic is done in GF(2^8) and uses the generator polynomial 0x11D.

The deltas arrive on a valid/ready stream. The highest disk comes first and the order descends to `start_idx`. Disks above `stop_idx` are never presented. Disks below `start_idx` supply no data, but they still carry weight in Q. After the last delta, the block spends one clock per such disk to multiply the partial Q delta by the generator 2. During that phase it holds `dlt_ready` low. The following cycle it pulses `out_valid` with the results. A column whose start index is larger than its stop index is refused with a one-cycle error pulse.

Top module: `pq_rmw_updater`

## Requirements
- R1: After reset, `out_valid` and `cfg_err` are 0 and `dlt_ready` is 1.
- R2: For each column, `new_p` equals `old_p` XOR the deltas of every disk from `start_idx` to `stop_idx`.
- R3: For each column, `new_q` equals `old_q` XOR the sum over disks z in the range of 2^z times delta_z in GF(2^8). Multiplying a byte by 2 shifts it left one bit and XORs in 0x1D when the bit shifted out (bit 7) was 1.
- R4: Byte lanes are independent. Lane k of `new_p`/`new_q` (bits 8k+7..8k) depends only on lane k of the inputs.
- R5: When `start_idx` equals `stop_idx`, exactly one delta is taken. When both are 0, `out_valid` rises in the cycle right after that delta is accepted.
- R6: After the last delta is accepted, `dlt_ready` stays low for exactly `start_idx` cycles. `out_valid` is high in the cycle that follows the final doubling, and it stays high for one cycle.
- R7: `start_idx`, `stop_idx` and `old_q` are sampled when the first delta of a column is accepted. Later changes to them within the column do not affect the result.
- R8: If the first delta is accepted with `start_idx` > `stop_idx`, `cfg_err` pulses for one cycle in the following cycle. No `out_valid` follows, and the block is ready for a new column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_idx | input | IDX_W | Lowest changed disk index, sampled with the first delta |
| stop_idx | input | IDX_W | Highest changed disk index, sampled with the first delta |
| old_p | input | 8*LANES | Existing P word, sampled with the first delta |
| old_q | input | 8*LANES | Existing Q word, sampled with the first delta |
| dlt_valid | input | 1 | Delta word present |
| dlt_data | input | 8*LANES | Delta (old XOR new data) of the current disk |
| dlt_ready | output | 1 | Block accepts a delta this cycle |
| out_valid | output | 1 | One-cycle strobe: new P and Q are valid |
| new_p | output | 8*LANES | Updated P word |
| new_q | output | 8*LANES | Updated Q word |
| cfg_err | output | 1 | One-cycle pulse: a column with start above stop was refused |

## Verification
A 3-bit index configuration is swept over every (start, stop) pair. Each pair is run with random deltas and again with deltas in lane 0 only. The full sweep separates errors in the doubling count below `start_idx` from errors in the stream phase, because each disk index then gets its own power of 2. The lane-0-only pattern shows any leakage between lanes, and a delta with bit 7 set exercises the polynomial reduction. The indices and old Q are scrambled after the first accept to show that they are latched. The 28 refused pairs confirm that an error pulse appears and no result strobe follows.

// File: rtl/pq_rmw_pkg.sv
package pq_rmw_pkg;

    localparam logic [7:0] GF_POLY_LOW = 8'h1D;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_SHIFT = 2'd2
    } pq_state_e;

    typedef struct packed {
        logic ld;   // first delta of a column
        logic acc;  // further delta absorbed
        logic shf;  // data-free doubling
        logic fin;  // results written this cycle
    } pq_op_t;

    function automatic logic [7:0] gf_times2(input logic [7:0] b);
        return {b[6:0], 1'b0} ^ (b[7] ? GF_POLY_LOW : 8'h00);
    endfunction

endpackage

// File: rtl/gf_dbl_word.sv
module gf_dbl_word
    import pq_rmw_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign dout[8*l +: 8] = gf_times2(din[8*l +: 8]);
    end
endmodule

// File: rtl/pq_ctrl.sv
module pq_ctrl
    import pq_rmw_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dlt_valid,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [IDX_W-1:0] stop_idx,
    output logic             dlt_ready,
    output pq_op_t           op,
    output logic             out_valid,
    output logic             cfg_err
);
    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    pq_state_e        st, nxt;
    logic [IDX_W-1:0] start_l, rem, cnt;
    logic             fire, bad;

    assign dlt_ready = (st != ST_SHIFT);
    assign fire      = dlt_valid && dlt_ready;

    always_comb begin
        op  = '0;
        nxt = st;
        bad = 1'b0;
        case (st)
            ST_IDLE: if (fire) begin
                if (start_idx > stop_idx) begin
                    bad = 1'b1;
                end else begin
                    op.ld = 1'b1;
                    if (start_idx == stop_idx) begin
                        op.fin = (start_idx == '0);
                        nxt    = (start_idx == '0) ? ST_IDLE : ST_SHIFT;
                    end else begin
                        nxt = ST_ACCUM;
                    end
                end
            end
            ST_ACCUM: if (fire) begin
                op.acc = 1'b1;
                if (rem == ONE) begin
                    op.fin = (start_l == '0);
                    nxt    = (start_l == '0) ? ST_IDLE : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                op.shf = 1'b1;
                if (cnt == ONE) begin
                    op.fin = 1'b1;
                    nxt    = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            start_l   <= '0;
            rem       <= '0;
            cnt       <= '0;
            out_valid <= 1'b0;
            cfg_err   <= 1'b0;
        end else begin
            st        <= nxt;
            out_valid <= op.fin;
            cfg_err   <= bad;
            if (op.ld) begin
                start_l <= start_idx;
                rem     <= stop_idx - start_idx;
                cnt     <= start_idx;
            end
            if (op.acc) rem <= rem - ONE;
            if (op.shf) cnt <= cnt - ONE;
        end
    end

    // R1: quiet outputs after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !cfg_err && dlt_ready));

    // R5: single delta at index 0 gives a strobe on the next cycle
    assert_single_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && dlt_valid && start_idx == '0 && stop_idx == '0) |=> out_valid);

    // R6: the last doubling is followed by the strobe and a ready block
    assert_shift_end_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && cnt == ONE) |=> (out_valid && dlt_ready));

    // R7: latched start index does not move inside a column
    assert_start_held_R7: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(start_l));

    // R8: a refused column never produces a result strobe
    assert_err_no_out_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !out_valid);

endmodule

// File: rtl/pq_dp.sv
module pq_dp
    import pq_rmw_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  pq_op_t             op,
    input  logic [8*LANES-1:0] dlt_data,
    input  logic [8*LANES-1:0] old_p,
    input  logic [8*LANES-1:0] old_q,
    output logic [8*LANES-1:0] new_p,
    output logic [8*LANES-1:0] new_q
);
    localparam int W = 8 * LANES;

    logic [W-1:0] p_acc, q_acc, oldq_l, q_dbl, p_nxt, q_nxt;

    gf_dbl_word #(.LANES(LANES)) u_dbl (.din(q_acc), .dout(q_dbl));

    always_comb begin
        p_nxt = p_acc;
        q_nxt = q_acc;
        if (op.ld) begin
            p_nxt = old_p ^ dlt_data;
            q_nxt = dlt_data;
        end else if (op.acc) begin
            p_nxt = p_acc ^ dlt_data;
            q_nxt = q_dbl ^ dlt_data;
        end else if (op.shf) begin
            q_nxt = q_dbl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_acc  <= '0;
            q_acc  <= '0;
            oldq_l <= '0;
            new_p  <= '0;
            new_q  <= '0;
        end else begin
            p_acc <= p_nxt;
            q_acc <= q_nxt;
            if (op.ld) oldq_l <= old_q;
            if (op.fin) begin
                new_p <= p_nxt;
                new_q <= (op.ld ? old_q : oldq_l) ^ q_nxt;
            end
        end
    end

    // R4: with a zero delta, a doubling step keeps P unchanged
    assert_p_hold_on_shift_R4: assert property (@(posedge clk) disable iff (rst)
        op.shf |=> $stable(p_acc));

endmodule

// File: rtl/pq_rmw_updater.sv
module pq_rmw_updater
    import pq_rmw_pkg::*;
#(
    parameter int LANES = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   start_idx,
    input  logic [IDX_W-1:0]   stop_idx,
    input  logic [8*LANES-1:0] old_p,
    input  logic [8*LANES-1:0] old_q,
    input  logic               dlt_valid,
    input  logic [8*LANES-1:0] dlt_data,
    output logic               dlt_ready,
    output logic               out_valid,
    output logic [8*LANES-1:0] new_p,
    output logic [8*LANES-1:0] new_q,
    output logic               cfg_err
);
    pq_op_t op;

    pq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .dlt_valid(dlt_valid),
        .start_idx(start_idx), .stop_idx(stop_idx),
        .dlt_ready(dlt_ready), .op(op),
        .out_valid(out_valid), .cfg_err(cfg_err)
    );

    pq_dp #(.LANES(LANES)) u_dp (
        .clk(clk), .rst(rst), .op(op), .dlt_data(dlt_data),
        .old_p(old_p), .old_q(old_q), .new_p(new_p), .new_q(new_q)
    );
endmodule

// File: tb/pq_rmw_updater_tb_top.sv
`timescale 1ns/1ps
module pq_rmw_updater_tb_top;
    localparam int LANES = 4;
    localparam int IDX_W = 3;
    localparam int W     = 8 * LANES;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IDX_W-1:0] start_idx = '0, stop_idx = '0;
    logic [W-1:0]     old_p = '0, old_q = '0, dlt_data = '0;
    logic             dlt_valid = 1'b0;
    logic             dlt_ready, out_valid, cfg_err;
    logic [W-1:0]     new_p, new_q;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pq_rmw_updater #(.LANES(LANES), .IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst(rst), .start_idx(start_idx), .stop_idx(stop_idx),
        .old_p(old_p), .old_q(old_q), .dlt_valid(dlt_valid), .dlt_data(dlt_data),
        .dlt_ready(dlt_ready), .out_valid(out_valid), .new_p(new_p), .new_q(new_q),
        .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mul2(input logic [7:0] b);
        logic [8:0] t;
        t = {b, 1'b0};
        if (t[8]) t = t ^ 9'h11D;
        return t[7:0];
    endfunction

    task automatic run_col(input int s, input int e, input int mode);
        logic [W-1:0] d [8];
        logic [W-1:0] op_v, oq_v, ep, eq;
        int w;
        op_v = $urandom; oq_v = $urandom;
        for (int z = 0; z < 8; z++) begin
            d[z] = (mode == 1) ? {{(W-8){1'b0}}, 8'($urandom) | 8'h80} : W'($urandom);
        end
        ep = op_v; eq = oq_v;
        for (int z = s; z <= e; z++) begin
            ep = ep ^ d[z];
            for (int l = 0; l < LANES; l++) begin
                logic [7:0] t;
                t = d[z][8*l +: 8];
                for (int k = 0; k < z; k++) t = mul2(t);
                eq[8*l +: 8] = eq[8*l +: 8] ^ t;
            end
        end
        @(negedge clk);
        start_idx = IDX_W'(s); stop_idx = IDX_W'(e);
        old_p = op_v; old_q = oq_v; dlt_valid = 1'b1;
        for (int z = e; z >= s; z--) begin
            dlt_data = d[z];
            @(posedge clk); @(negedge clk);
            start_idx = IDX_W'($urandom); stop_idx = IDX_W'($urandom);
            old_p = $urandom; old_q = $urandom;
        end
        dlt_valid = 1'b0;
        w = 0;
        while (!out_valid && w < 20) begin
            chk(dlt_ready == 1'b0, "R6 ready low while doubling", W'(dlt_ready), '0);
            @(posedge clk); @(negedge clk);
            w++;
        end
        chk(w == s, (s == e) ? "R5 R6 strobe latency" : "R6 strobe latency", W'(w), W'(s));
        chk(new_p == ep, "R2 R7 new P", new_p, ep);
        chk(new_q == eq, "R3 R7 new Q", new_q, eq);
        if (mode == 1) begin
            chk(new_q[W-1:8] == oq_v[W-1:8], "R4 untouched Q lanes", new_q, oq_v);
            chk(new_p[W-1:8] == op_v[W-1:8], "R4 untouched P lanes", new_p, op_v);
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 strobe one cycle", W'(out_valid), '0);
    endtask

    task automatic run_bad(input int s, input int e);
        @(negedge clk);
        start_idx = IDX_W'(s); stop_idx = IDX_W'(e);
        dlt_data = $urandom; dlt_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        dlt_valid = 1'b0;
        chk(cfg_err == 1'b1, "R8 error pulse", W'(cfg_err), W'(1));
        chk(out_valid == 1'b0, "R8 no strobe", W'(out_valid), '0);
        @(negedge clk);
        chk(cfg_err == 1'b0 && out_valid == 1'b0 && dlt_ready == 1'b1,
            "R8 back to idle", W'({cfg_err, out_valid, dlt_ready}), W'(1));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R1 out_valid after reset", W'(out_valid), '0);
        chk(cfg_err == 1'b0, "R1 cfg_err after reset", W'(cfg_err), '0);
        chk(dlt_ready == 1'b1, "R1 ready after reset", W'(dlt_ready), W'(1));
        for (int rnd = 0; rnd < 3; rnd++) begin
            for (int s = 0; s < 8; s++) begin
                for (int e = 0; e < 8; e++) begin
                    if (s <= e) run_col(s, e, (rnd == 2) ? 1 : 0);
                    else if (rnd == 0) run_bad(s, e);
                end
            end
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule